// File: doc/BRIEF.md
# Pipelined Serial Converter Link Sequencer

This block runs one serial link to a successive-approximation converter. It drives an active-low chip select and a gated converter clock. The converter clock is derived from the system clock by a programmable divider. Every conversion takes three chip-select frames in a fixed order. In the first frame the block shifts out an 8-bit control word. In the second frame the converter samples and converts. In the third frame the block shifts in the 16-bit result, on one data lane or on two.

Events arrive through a valid/ready handshake. Each event carries an identifier, a channel number and a simultaneous-sampling flag. The link is pipelined. The frame that carries one event's control word also holds the conversion of the event before it and the readout of the event before that. So up to three events are in flight at once, and a steady burst yields one result per frame. Each finished result is presented for one cycle together with its event identifier.

Frame shape is set by four counts, all in converter-clock periods: setup from the chip-select fall to the first pulse, the number of pulses, hold from the last pulse to the chip-select rise, and the gap with chip select high. When the link has been idle, a fixed start latency in system clocks comes before the first frame.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, adcCsN is 1, adcSclk is 0, adcDout is 0, resValid is 0, and evtReady is 1.
- R2: One converter-clock period lasts clkDiv+1 system cycles, with clkDiv at least 1. During a pulse period, adcSclk is high for the first floor((clkDiv+1)/2) cycles of the period and low for the rest.
- R3: A frame lasts tCsck+nck+tCkcs+tCsCs periods, with tCsCs at least 1. adcCsN is low for the first tCsck+nck+tCkcs periods and high for the rest. Clock pulses fall only in periods tCsck to tCsck+nck-1.
- R4: The control word is {channel[3:0], low nibble}, where the low nibble is 4'hF when evtSimul is 1 and 4'hD when it is 0. It goes out on adcDout MSB first, one bit per pulse period, in the first 8 pulse periods of its frame. adcDout is 0 at all other times.
- R5: The inputs are sampled in the last system cycle of each pulse period. In single-lane mode, adcDin0 carries the result MSB first over 16 pulses. In dual-lane mode, each pulse carries two bits over 8 pulses: adcDin0 carries the more significant bit and adcDin1 the next bit.
- R6: An event whose control word goes out in frame k has its result read in frame k+2. Frames run back to back while any event is in flight, so a continuous stream of events gives results exactly one frame length apart, in acceptance order, with matching resId.
- R7: resValid is a one-cycle pulse. It comes in the cycle after the last result bit is sampled, with the full word on resData.
- R8: When an event is accepted while the link is idle, adcCsN first goes low START_LAT system cycles after the accepting clock edge.
- R9: evtReady is 1 only while idle or in the final system cycle of a frame. The block returns to idle after the frame in which no event is left in flight.
- R10: Each chip-select assertion contains exactly nck rising edges of adcSclk, and adcSclk is never high while adcCsN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkDiv | input | DIV_W | Converter clock divider (period = clkDiv+1) |
| tCsck | input | TIM_W | Periods from chip-select fall to first pulse |
| nck | input | NCK_W | Clock pulses per chip-select assertion |
| tCkcs | input | TIM_W | Periods from last pulse to chip-select rise |
| tCsCs | input | TIM_W | Periods with chip select high between frames |
| dualLane | input | 1 | 1 selects two result lanes |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event taken on this edge when valid |
| evtId | input | 5 | Event identifier |
| evtChan | input | 4 | Converter channel |
| evtSimul | input | 1 | Simultaneous-sampling flag |
| adcCsN | output | 1 | Chip select, active low |
| adcSclk | output | 1 | Gated converter clock |
| adcDout | output | 1 | Control word serial out |
| adcDin0 | input | 1 | Result lane 0 |
| adcDin1 | input | 1 | Result lane 1 (dual mode) |
| resValid | output | 1 | Result pulse |
| resId | output | 5 | Identifier of the result |
| resData | output | 16 | Result word |

## Verification
The bound checker watches framing on every cycle. It checks that clock pulses and control bits occur only while chip select is low, that the pulse count in each assertion never exceeds nck, that a nonzero setup keeps the clock low at the chip-select fall, and that the result strobe is a single cycle. The bench scenarios are the only place to show the three-frame pipeline offset, the word encoding and lane bit order (through a converter model that decodes the control words), the result spacing in a burst, and the start latency from idle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int ID_W   = 5;
  localparam int CHAN_W = 4;
  localparam int WORD_W = 8;
  localparam int RES_W  = 16;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [CHAN_W-1:0] chan;
    logic              simul;
  } slot_t;

  typedef struct packed {
    logic loadIdle;
    logic frameEnd;
    logic acceptRun;
    logic tick;
    logic clkWin;
  } strobe_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int TIM_W     = 5,
  parameter int NCK_W     = 5,
  parameter int CNT_W     = 7,
  parameter int START_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [TIM_W-1:0] tCsck,
  input  logic [NCK_W-1:0] nck,
  input  logic [TIM_W-1:0] tCkcs,
  input  logic [TIM_W-1:0] tCsCs,
  input  logic             evtValid,
  input  logic             ctrlBusy,
  input  logic             convBusy,
  output logic             evtReady,
  output logic             csN,
  output logic             sclk,
  output logic [CNT_W-1:0] bitIdx,
  output strobe_t          stb
);
  localparam int LAT_W = $clog2(START_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_RUN} state_t;

  state_t           state;
  logic [LAT_W-1:0] latCnt;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] aCnt;

  logic [CNT_W-1:0] clkBeg, clkEnd, csLen, frameLen;
  logic [DIV_W:0]   hiLen;
  logic             running, tick, lastA, keepGoing;

  assign clkBeg   = CNT_W'(tCsck);
  assign clkEnd   = clkBeg + CNT_W'(nck);
  assign csLen    = clkEnd + CNT_W'(tCkcs);
  assign frameLen = csLen + CNT_W'(tCsCs);
  assign hiLen    = ({1'b0, clkDiv} + 1'b1) >> 1;

  assign running   = (state == S_RUN);
  assign tick      = running && (divCnt == clkDiv);
  assign lastA     = (aCnt == frameLen - 1'b1);
  assign keepGoing = ctrlBusy || convBusy || evtValid;

  assign stb.tick      = tick;
  assign stb.clkWin    = running && (aCnt >= clkBeg) && (aCnt < clkEnd);
  assign stb.frameEnd  = tick && lastA;
  assign stb.acceptRun = tick && lastA && evtValid;
  assign stb.loadIdle  = (state == S_IDLE) && evtValid;

  assign evtReady = (state == S_IDLE) || (tick && lastA);
  assign csN      = !(running && (aCnt < csLen));
  assign sclk     = stb.clkWin && ({1'b0, divCnt} < hiLen);
  assign bitIdx   = aCnt - clkBeg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      latCnt <= '0;
      divCnt <= '0;
      aCnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (evtValid) begin
            state  <= S_START;
            latCnt <= '0;
          end
        end
        S_START: begin
          if (latCnt == LAT_W'(START_LAT - 1)) begin
            state  <= S_RUN;
            divCnt <= '0;
            aCnt   <= '0;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        S_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (lastA) begin
              aCnt <= '0;
              if (!keepGoing) state <= S_IDLE;
            end else begin
              aCnt <= aCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_dp.sv
module adcseq_dp
  import adcseq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CNT_W-1:0]  bitIdx,
  input  logic              dualLane,
  input  logic [ID_W-1:0]   evtId,
  input  logic [CHAN_W-1:0] evtChan,
  input  logic              evtSimul,
  input  logic              dinLo,
  input  logic              dinHi,
  output logic              ctrlBusy,
  output logic              convBusy,
  output logic              dout,
  output logic              resValid,
  output logic [ID_W-1:0]   resId,
  output logic [RES_W-1:0]  resData
);
  localparam logic [3:0] NIB_SIM = 4'hF;
  localparam logic [3:0] NIB_SEQ = 4'hD;

  slot_t ctrlS, convS, dataS, newSlot;
  logic [WORD_W-1:0] ctrlWord;
  logic [RES_W-1:0]  rxSh, nextRx;
  logic [CNT_W-1:0]  needBits;
  logic              capEn, lastCap;

  assign newSlot  = '{valid: 1'b1, id: evtId, chan: evtChan, simul: evtSimul};
  assign ctrlWord = {ctrlS.chan, (ctrlS.simul ? NIB_SIM : NIB_SEQ)};
  assign ctrlBusy = ctrlS.valid;
  assign convBusy = convS.valid;

  assign dout = ctrlS.valid && stb.clkWin && (bitIdx < CNT_W'(WORD_W))
                && ctrlWord[~bitIdx[2:0]];

  assign needBits = dualLane ? CNT_W'(RES_W / 2) : CNT_W'(RES_W);
  assign capEn    = stb.tick && stb.clkWin && (bitIdx < needBits);
  assign lastCap  = capEn && (bitIdx == needBits - 1'b1);
  assign nextRx   = dualLane ? {rxSh[RES_W-3:0], dinLo, dinHi}
                             : {rxSh[RES_W-2:0], dinLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlS <= '0;
      convS <= '0;
      dataS <= '0;
    end else if (stb.loadIdle) begin
      ctrlS <= newSlot;
    end else if (stb.frameEnd) begin
      dataS <= convS;
      convS <= ctrlS;
      ctrlS <= stb.acceptRun ? newSlot : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh     <= '0;
      resValid <= 1'b0;
      resId    <= '0;
      resData  <= '0;
    end else begin
      if (stb.frameEnd)  rxSh <= '0;
      else if (capEn)    rxSh <= nextRx;
      resValid <= lastCap && dataS.valid;
      if (lastCap && dataS.valid) begin
        resId   <= dataS.id;
        resData <= nextRx;
      end
    end
  end
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adcseq_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int TIM_W     = 5,
  parameter int NCK_W     = 5,
  parameter int START_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [TIM_W-1:0]  tCsck,
  input  logic [NCK_W-1:0]  nck,
  input  logic [TIM_W-1:0]  tCkcs,
  input  logic [TIM_W-1:0]  tCsCs,
  input  logic              dualLane,
  input  logic              evtValid,
  output logic              evtReady,
  input  logic [ID_W-1:0]   evtId,
  input  logic [CHAN_W-1:0] evtChan,
  input  logic              evtSimul,
  output logic              adcCsN,
  output logic              adcSclk,
  output logic              adcDout,
  input  logic              adcDin0,
  input  logic              adcDin1,
  output logic              resValid,
  output logic [ID_W-1:0]   resId,
  output logic [RES_W-1:0]  resData
);
  localparam int CNT_W = ((TIM_W > NCK_W) ? TIM_W : NCK_W) + 2;

  strobe_t          stb;
  logic [CNT_W-1:0] bitIdx;
  logic             ctrlBusy, convBusy;

  adcseq_ctrl #(
    .DIV_W(DIV_W), .TIM_W(TIM_W), .NCK_W(NCK_W),
    .CNT_W(CNT_W), .START_LAT(START_LAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .tCsck(tCsck), .nck(nck),
    .tCkcs(tCkcs), .tCsCs(tCsCs), .evtValid(evtValid),
    .ctrlBusy(ctrlBusy), .convBusy(convBusy), .evtReady(evtReady),
    .csN(adcCsN), .sclk(adcSclk), .bitIdx(bitIdx), .stb(stb)
  );

  adcseq_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx), .dualLane(dualLane),
    .evtId(evtId), .evtChan(evtChan), .evtSimul(evtSimul),
    .dinLo(adcDin0), .dinHi(adcDin1), .ctrlBusy(ctrlBusy), .convBusy(convBusy),
    .dout(adcDout), .resValid(resValid), .resId(resId), .resData(resData)
  );
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
  import adcseq_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int TIM_W = 5,
  parameter int NCK_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [TIM_W-1:0]  tCsck,
  input logic [NCK_W-1:0]  nck,
  input logic              adcCsN,
  input logic              adcSclk,
  input logic              adcDout,
  input logic              resValid
);
  logic             sclkQ;
  logic [NCK_W:0]   pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      pulseCnt <= '0;
    end else begin
      sclkQ <= adcSclk;
      if (adcCsN)                 pulseCnt <= '0;
      else if (adcSclk && !sclkQ) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // R10: clock pulses only inside a chip-select assertion
  p_clk_in_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    adcSclk |-> !adcCsN);

  // R10: no more than nck pulses per assertion
  p_pulse_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= {1'b0, nck});

  // R4: control bits only inside a chip-select assertion
  p_dout_in_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    adcDout |-> !adcCsN);

  // R3: nonzero setup keeps the clock low when chip select falls
  p_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((tCsck != '0) && $fell(adcCsN)) |-> !adcSclk);

  // R7: result strobe lasts one cycle
  p_res_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DIV_W(DIV_W), .TIM_W(TIM_W), .NCK_W(NCK_W)) uChk (.*);

// File: tb/tb_adc_serial_seq.sv
module tb_adc_serial_seq;
  localparam int CLK_PERIOD = 10;
  localparam int START_LAT  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] clkDiv = 4'd1;
  logic [4:0] tCsck = 5'd1, nck = 5'd16, tCkcs = 5'd0, tCsCs = 5'd2;
  logic dualLane = 1'b0;
  logic evtValid = 1'b0;
  logic evtReady;
  logic [4:0] evtId = '0;
  logic [3:0] evtChan = '0;
  logic evtSimul = 1'b0;
  logic adcCsN, adcSclk, adcDout;
  logic adcDin0 = 1'b0, adcDin1 = 1'b0;
  logic resValid;
  logic [4:0] resId;
  logic [15:0] resData;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_seq #(.START_LAT(START_LAT)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  int mState = 0, mLat = 0, mDiv = 0, mA = 0, cyc = 0;
  bit pV[3];
  int pId[3];
  bit mRes = 0;
  int mResId = 0;
  int expId[$];
  int expData[$];
  int nAcc = 0;
  int accCyc = 0;
  bit latPending = 0;
  int resCyc[$];

  function automatic int frameLen();
    return int'(tCsck) + int'(nck) + int'(tCkcs) + int'(tCsCs);
  endfunction

  task automatic takeEvent();
    expId.push_back(int'(evtId));
    expData.push_back(int'({evtChan, 3'b101, evtSimul, nAcc[7:0]}));
    nAcc++;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mLat = 0; mDiv = 0; mA = 0; mRes = 0;
      pV = '{0, 0, 0};
    end else begin
      cyc++;
      mRes = 0;
      case (mState)
        0: if (evtValid) begin
             takeEvent();
             pV[0] = 1; pId[0] = int'(evtId);
             mState = 1; mLat = 0;
             accCyc = cyc; latPending = 1;
           end
        1: if (mLat == START_LAT - 1) begin mState = 2; mDiv = 0; mA = 0; end
           else mLat++;
        default: begin
          if (mDiv == int'(clkDiv)) begin
            int b, need;
            b = mA - int'(tCsck);
            need = dualLane ? 8 : 16;
            if (mA >= int'(tCsck) && mA < int'(tCsck) + int'(nck) && b == need - 1 && pV[2]) begin
              mRes = 1; mResId = pId[2];
            end
            mDiv = 0;
            if (mA == frameLen() - 1) begin
              pV[2] = pV[1]; pId[2] = pId[1];
              pV[1] = pV[0]; pId[1] = pId[0];
              pV[0] = 0;
              if (evtValid) begin
                takeEvent();
                pV[0] = 1; pId[0] = int'(evtId);
              end
              mA = 0;
              if (!pV[0] && !pV[1] && !pV[2]) mState = 0;
            end else mA++;
          end else mDiv++;
        end
      endcase
    end
  end

  // ---------------- converter model ----------------
  bit prevCs = 1, prevSclk = 0;
  int k = 0;
  logic [7:0] curW;
  bit curV = 0, st1V = 0, st2V = 0;
  int curVal = 0, st1Val = 0, st2Val = 0, nConv = 0;
  logic [15:0] outW = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !adcCsN) begin
        st2V = st1V; st2Val = st1Val;
        st1V = curV; st1Val = curVal;
        curV = 0; k = 0;
        outW = st2V ? 16'(st2Val) : 16'h0;
      end
      if (!adcCsN && adcSclk && !prevSclk) begin
        if (k < 8) curW[7-k] = adcDout;
        if (k == 7 && (curW[3:0] == 4'hF || curW[3:0] == 4'hD)) begin
          curV = 1;
          curVal = int'({curW[7:4], 3'b101, curW[1], nConv[7:0]});
          nConv++;
        end
        if (dualLane) begin
          adcDin0 = (k < 8) ? outW[15-2*k] : 1'b0;
          adcDin1 = (k < 8) ? outW[14-2*k] : 1'b0;
        end else begin
          adcDin0 = (k < 16) ? outW[15-k] : 1'b0;
          adcDin1 = 1'b0;
        end
        k++;
      end
    end
    prevCs = adcCsN; prevSclk = adcSclk;
  end

  // ---------------- per-cycle comparison ----------------
  bit monCsPrev = 1, monSclkPrev = 0;
  int pulses = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      check(adcCsN == 1 && adcSclk == 0 && adcDout == 0, "R1 idle pins", {adcCsN, adcSclk, adcDout}, 3'b100);
      check(resValid == 0 && evtReady == 1, "R1 handshake", {resValid, evtReady}, 2'b01);
    end else begin
      bit eCs, eSclk, eRdy;
      eCs  = !(mState == 2 && mA < int'(tCsck) + int'(nck) + int'(tCkcs));
      eSclk = mState == 2 && mA >= int'(tCsck) && mA < int'(tCsck) + int'(nck)
              && mDiv < (int'(clkDiv) + 1) / 2;
      eRdy = mState == 0 || (mState == 2 && mDiv == int'(clkDiv) && mA == frameLen() - 1);
      check(adcCsN == eCs, "R3 chip select", adcCsN, eCs);
      check(adcSclk == eSclk, "R2 clock shape", adcSclk, eSclk);
      check(evtReady == eRdy, "R9 ready", evtReady, eRdy);
      check(resValid == mRes, "R7 result strobe", resValid, mRes);
      if (resValid) begin
        resCyc.push_back(cyc);
        if (expId.size() > 0) begin
          int eI, eD;
          eI = expId.pop_front(); eD = expData.pop_front();
          check(int'(resId) == eI, "R6 result order", resId, eI);
          check(int'(resData) == eD, "R5 R4 result word", resData, eD);
        end else check(0, "R6 unexpected result", resId, 0);
      end
      if (latPending && !adcCsN) begin
        check(cyc - accCyc == START_LAT, "R8 start latency", cyc - accCyc, START_LAT);
        latPending = 0;
      end
      if (!adcCsN && adcSclk && !monSclkPrev) pulses++;
      if (!monCsPrev && adcCsN) begin
        check(pulses == int'(nck), "R10 pulses per frame", pulses, nck);
        pulses = 0;
      end
      monCsPrev = adcCsN; monSclkPrev = adcSclk;
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendEvt(input int id, input int ch, input bit sim);
    evtValid = 1; evtId = 5'(id); evtChan = 4'(ch); evtSimul = sim;
    while (!evtReady) @(negedge clk);
    @(negedge clk);
    evtValid = 0;
  endtask

  task automatic waitDrain();
    while (!(mState == 0 && expId.size() == 0)) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic checkSpacing(input int first, input string tag);
    int per;
    per = frameLen() * (int'(clkDiv) + 1);
    for (int i = first + 1; i < resCyc.size(); i++)
      check(resCyc[i] - resCyc[i-1] == per, tag, resCyc[i] - resCyc[i-1], per);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // A: single lane, one event then a burst
    sendEvt(1, 3, 1);
    waitDrain();
    resCyc.delete();
    for (int i = 0; i < 5; i++) sendEvt(2 + i, i + 5, i[0]);
    waitDrain();
    checkSpacing(0, "R6 single-lane spacing");

    // B: dual lane, 18-period frames, six back to back
    clkDiv = 4'd1; tCsck = 5'd1; nck = 5'd8; tCkcs = 5'd0; tCsCs = 5'd9; dualLane = 1;
    @(negedge clk);
    resCyc.delete();
    for (int i = 0; i < 6; i++) sendEvt(10 + i, 15 - i, ~i[0]);
    waitDrain();
    check(resCyc.size() == 6, "R6 burst count", resCyc.size(), 6);
    checkSpacing(0, "R6 dual-lane spacing");

    // C: odd divider, zero setup, hold, gaps between events
    clkDiv = 4'd2; tCsck = 5'd0; nck = 5'd8; tCkcs = 5'd2; tCsCs = 5'd2;
    @(negedge clk);
    sendEvt(20, 1, 0);
    sendEvt(21, 2, 1);
    repeat (40) @(negedge clk);
    sendEvt(22, 9, 0);
    waitDrain();
    sendEvt(23, 0, 1);
    waitDrain();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule